// File: doc/BRIEF.md
# Host-to-Controller Mailbox Register Block

This block is a small register window through which a host processor trades bytes with a system-management microcontroller. The host sees three 32-bit registers (interrupt control, data and status) selected by a word offset. A byte the host writes to the data register enters a transmit FIFO, and the microcontroller drains it through a pop handshake. Bytes the microcontroller pushes enter a receive FIFO, and the host takes them by reading the data register. In both directions the byte travels in bits 15:8 of the data word.

Four conditions are watched: transmit empty, transmit not full, receive not empty and receive overflow. Each one sets a sticky status flag, which the host acknowledges by writing ones to the status register. Each condition also has an arm bit and a mask bit in the interrupt register. A single level interrupt output is high while any flag is set with both of its bits set. A typical host arms and masks only receive-not-empty, then pulls replies byte by byte after sending a command.

Top module: `mbox_regif`

## Requirements
- R1: After reset the status register (offset 2) reads 0x3, the interrupt register (offset 0) reads 0, `irq` is low, and a data read (offset 1) returns 0.
- R2: A host write to offset 1 queues bits 15:8 of the write data into the transmit FIFO, and all other bits are ignored. The microcontroller sees the oldest byte on `mcu_tx_data` while `mcu_tx_valid` is high, and `mcu_tx_pop` removes it, in first-in first-out order.
- R3: A byte pushed by the microcontroller is returned to a host read of offset 1 in bits 15:8, with all other bits zero, in first-in first-out order.
- R4: A data read while the receive FIFO is empty returns zero and removes nothing, so the next pushed byte is the next byte read.
- R5: Each FIFO holds 8 bytes. A host data write into a full transmit FIFO is dropped.
- R6: A push into a full receive FIFO discards the byte and latches status bit 3 (overflow). `mcu_rx_ready` is low exactly while the receive FIFO is full.
- R7: Status bits 0..3 are transmit empty, transmit not full, receive not empty and receive overflow. Writing a one to a bit clears it, and writing zero leaves it alone. A cleared bit stays clear unless its condition still holds.
- R8: A flag latches on the clock edge after its condition is seen and stays set until cleared. If a condition is present in the same cycle as a clear of its bit, the bit stays set.
- R9: Interrupt register bits 0..3 are arm bits and bits 4..7 are mask bits, both in status-bit order. Both read back as written. Bits 31:8 read zero and writes to them are ignored.
- R10: `irq` is high exactly when some status bit is set and both its arm bit and its mask bit are set.
- R11: Offsets 3 to 7 read zero, and writes to them change no register or FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 3 | Register word offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops receive FIFO at offset 1) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the selected offset |
| irq | output | 1 | Level interrupt request |
| mcu_rx_push | input | 1 | Microcontroller pushes a byte toward the host |
| mcu_rx_data | input | 8 | Byte to push |
| mcu_rx_ready | output | 1 | Receive FIFO has room |
| mcu_tx_pop | input | 1 | Microcontroller takes the oldest host byte |
| mcu_tx_data | output | 8 | Oldest host byte |
| mcu_tx_valid | output | 1 | Transmit FIFO holds a byte |

## Verification
A host write-one-to-clear of the overflow bit can land in the same cycle as a microcontroller push into a full receive FIFO. The bench provokes this by filling the receive FIFO, then raising the status write and the push on the same clock. It judges the result by reading status a cycle later and expecting bit 3 still set. A second lone clear must then drop it, and the drained bytes must show the colliding byte was discarded.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam int SEL_W    = 3;
   localparam logic [SEL_W-1:0] OFF_INT  = 3'd0;
   localparam logic [SEL_W-1:0] OFF_DATA = 3'd1;
   localparam logic [SEL_W-1:0] OFF_STAT = 3'd2;
   localparam int NSRC     = 4;
   localparam int SRC_TXE  = 0;
   localparam int SRC_TXNF = 1;
   localparam int SRC_RXNE = 2;
   localparam int SRC_RXOV = 3;
   localparam logic [NSRC-1:0] FLAG_RST = 4'b0011;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("mbox_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic [PTR_W:0]   cnt;
   logic             do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == (PTR_W+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= push_data;
   end

   // R5
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);
   // R4
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty);
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
   import mbox_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] cond,
   input  logic [NSRC-1:0] clr,
   input  logic            ctl_wr,
   input  logic [2*NSRC-1:0] ctl_wdata,
   output logic [NSRC-1:0] flags,
   output logic [NSRC-1:0] arm,
   output logic [NSRC-1:0] mask,
   output logic            irq
);
   logic [NSRC-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm  <= '0;
         mask <= '0;
      end else if (ctl_wr) begin
         arm  <= ctl_wdata[NSRC-1:0];
         mask <= ctl_wdata[2*NSRC-1:NSRC];
      end
   end

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[i] <= FLAG_RST[i];
            else        flags[i] <= (flags[i] && !clr[i]) || cond[i];
         end
         assign hit[i] = flags[i] && arm[i] && mask[i];

         // R8
         set_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cond[i] |=> flags[i]);
         // R7
         w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !cond[i]) |=> !flags[i]);
      end
   endgenerate

   assign irq = |hit;
endmodule

// File: rtl/mbox_regif.sv
module mbox_regif
   import mbox_pkg::*;
#(
   parameter int FIFO_DEPTH = 8,
   parameter int BYTE_W     = 8,
   parameter int BYTE_LSB   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  host_sel,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              irq,
   input  logic              mcu_rx_push,
   input  logic [BYTE_W-1:0] mcu_rx_data,
   output logic              mcu_rx_ready,
   input  logic              mcu_tx_pop,
   output logic [BYTE_W-1:0] mcu_tx_data,
   output logic              mcu_tx_valid
);
   localparam int BYTE_MSB = BYTE_LSB + BYTE_W - 1;

   generate
      if (BYTE_MSB > 31) begin : g_bad_lane
         $error("mbox_regif: byte lane exceeds data word");
      end
   endgenerate

   logic              wr_int, wr_data, wr_stat, rd_data;
   logic              tx_empty, tx_full, rx_empty, rx_full;
   logic [BYTE_W-1:0] rx_head;
   logic [NSRC-1:0]   cond, clr, flags, arm, mask;

   assign wr_int  = host_wr && (host_sel == OFF_INT);
   assign wr_data = host_wr && (host_sel == OFF_DATA);
   assign wr_stat = host_wr && (host_sel == OFF_STAT);
   assign rd_data = host_rd && (host_sel == OFF_DATA);

   mbox_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(wr_data), .push_data(host_wdata[BYTE_MSB:BYTE_LSB]),
      .pop(mcu_tx_pop), .head(mcu_tx_data),
      .empty(tx_empty), .full(tx_full));

   mbox_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(mcu_rx_push), .push_data(mcu_rx_data),
      .pop(rd_data), .head(rx_head),
      .empty(rx_empty), .full(rx_full));

   assign mcu_tx_valid = !tx_empty;
   assign mcu_rx_ready = !rx_full;

   always_comb begin
      cond           = '0;
      cond[SRC_TXE]  = tx_empty;
      cond[SRC_TXNF] = !tx_full;
      cond[SRC_RXNE] = !rx_empty;
      cond[SRC_RXOV] = mcu_rx_push && rx_full;
      clr            = wr_stat ? host_wdata[NSRC-1:0] : '0;
   end

   mbox_flags u_flags (
      .clk(clk), .rst_n(rst_n),
      .cond(cond), .clr(clr),
      .ctl_wr(wr_int), .ctl_wdata(host_wdata[2*NSRC-1:0]),
      .flags(flags), .arm(arm), .mask(mask), .irq(irq));

   always_comb begin
      host_rdata = '0;
      case (host_sel)
         OFF_INT:  host_rdata[2*NSRC-1:0] = {mask, arm};
         OFF_DATA: if (!rx_empty) host_rdata[BYTE_MSB:BYTE_LSB] = rx_head;
         OFF_STAT: host_rdata[NSRC-1:0] = flags;
         default:  host_rdata = '0;
      endcase
   end

   // R10
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|(flags & arm & mask)) && (|flags));
   // R11
   reserved_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel > OFF_STAT) |=> ($stable(arm) && $stable(mask)));
   // R6
   rx_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mcu_rx_push && !mcu_rx_ready) |=> flags[SRC_RXOV]);
endmodule

// File: tb/mbox_regif_bench.sv
module mbox_regif_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  host_sel = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        irq;
   logic        mcu_rx_push = 1'b0;
   logic [7:0]  mcu_rx_data = '0;
   logic        mcu_rx_ready;
   logic        mcu_tx_pop = 1'b0;
   logic [7:0]  mcu_tx_data;
   logic        mcu_tx_valid;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mbox_regif u_mbox_regif (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq(irq), .mcu_rx_push(mcu_rx_push), .mcu_rx_data(mcu_rx_data),
      .mcu_rx_ready(mcu_rx_ready), .mcu_tx_pop(mcu_tx_pop),
      .mcu_tx_data(mcu_tx_data), .mcu_tx_valid(mcu_tx_valid));

   // upper byte: host transmit byte, lower byte: controller receive byte
   localparam logic [15:0] VEC [6] = '{16'h3C81, 16'h00FF, 16'hA55A,
                                       16'hFF00, 16'h1234, 16'h7EE7};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic hwrite(input logic [2:0] sel, input logic [31:0] d);
      host_sel = sel; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic [2:0] sel, output logic [31:0] d);
      host_sel = sel; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic mpush(input logic [7:0] b);
      mcu_rx_data = b; mcu_rx_push = 1'b1;
      @(negedge clk);
      mcu_rx_push = 1'b0;
   endtask

   task automatic mpop(output logic [7:0] b);
      #1 b = mcu_tx_data;
      mcu_tx_pop = 1'b1;
      @(negedge clk);
      mcu_tx_pop = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      logic [31:0] r;
      logic [7:0]  b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();

      // R1 reset state
      hread(3'd2, r); check("R1 status", r, 32'h3);
      hread(3'd0, r); check("R1 intreg", r, 32'h0);
      check("R1 irq", {31'd0, irq}, 32'd0);
      hread(3'd1, r); check("R1 data", r, 32'h0);

      // vector walk: R2 / R3
      foreach (VEC[i]) begin
         hwrite(3'd1, {16'hDEAD, VEC[i][15:8], 8'hBE});
         mpush(VEC[i][7:0]);
      end
      idle();
      foreach (VEC[i]) begin
         check("R2 valid", {31'd0, mcu_tx_valid}, 32'd1);
         mpop(b); check("R2 tx byte", {24'd0, b}, {24'd0, VEC[i][15:8]});
         hread(3'd1, r); check("R3 rx byte", r, {16'd0, VEC[i][7:0], 8'd0});
      end
      idle();
      check("R2 drained", {31'd0, mcu_tx_valid}, 32'd0);
      // R4 empty read
      hread(3'd1, r); check("R4 empty read", r, 32'h0);
      mpush(8'h5D); idle();
      hread(3'd1, r); check("R4 no pointer move", r, 32'h5D00);
      idle();

      // R7 W1C
      hread(3'd2, r); check("R7 sticky rxne", r, 32'h7);
      hwrite(3'd2, 32'h0); idle();
      hread(3'd2, r); check("R7 zero write", r, 32'h7);
      hwrite(3'd2, r); idle();
      hread(3'd2, r); check("R7 writeback clears", r, 32'h3);

      // R5 transmit full
      for (int k = 0; k < 9; k++) hwrite(3'd1, {16'd0, 8'(8'h10 + k), 8'd0});
      hwrite(3'd2, 32'hF); idle();
      hread(3'd2, r); check("R5 full status", r, 32'h0);
      for (int k = 0; k < 8; k++) begin
         mpop(b); check("R5 tx order", {24'd0, b}, 32'h10 + k);
      end
      idle();
      check("R5 ninth dropped", {31'd0, mcu_tx_valid}, 32'd0);

      // R9 / R10 interrupt control
      hwrite(3'd0, 32'h44);
      hread(3'd0, r); check("R9 readback", r, 32'h44);
      idle();
      check("R10 irq idle", {31'd0, irq}, 32'd0);
      for (int k = 0; k < 8; k++) mpush(8'(8'hA0 + k));
      idle();
      check("R10 irq rxne", {31'd0, irq}, 32'd1);
      check("R6 ready low", {31'd0, mcu_rx_ready}, 32'd0);
      mpush(8'hEE); idle();
      hread(3'd2, r); check("R6 overflow flag", r, 32'hF);
      for (int k = 0; k < 8; k++) begin
         hread(3'd1, r); check("R6 kept bytes", r, {16'd0, 8'(8'hA0 + k), 8'd0});
      end
      hread(3'd1, r); check("R6 discarded", r, 32'h0);
      hwrite(3'd2, 32'hF); idle();
      hread(3'd2, r); check("R7 after drain", r, 32'h3);
      check("R10 irq cleared", {31'd0, irq}, 32'd0);
      hwrite(3'd0, 32'hFFFFFFFF);
      hread(3'd0, r); check("R9 upper ignored", r, 32'hFF);
      check("R10 txe source", {31'd0, irq}, 32'd1);
      hwrite(3'd0, 32'h0); idle();
      check("R10 disarmed", {31'd0, irq}, 32'd0);

      // R11 reserved offsets
      for (int s = 3; s < 8; s++) begin
         hwrite(3'(s), 32'hFFFFFFFF);
         hread(3'(s), r); check("R11 reads zero", r, 32'h0);
      end
      idle();
      hread(3'd0, r); check("R11 intreg kept", r, 32'h0);
      hread(3'd2, r); check("R11 status kept", r, 32'h3);
      check("R11 txq kept", {31'd0, mcu_tx_valid}, 32'd0);

      // R8 clear colliding with overflow
      for (int k = 0; k < 8; k++) mpush(8'(8'h60 + k));
      host_sel = 3'd2; host_wdata = 32'h8; host_wr = 1'b1;
      mcu_rx_data = 8'h99; mcu_rx_push = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; mcu_rx_push = 1'b0;
      idle();
      hread(3'd2, r); check("R8 set beats clear", r & 32'h8, 32'h8);
      hwrite(3'd2, 32'h8); idle();
      hread(3'd2, r); check("R8 lone clear", r & 32'h8, 32'h0);
      hwrite(3'd2, 32'h4); idle();
      hread(3'd2, r); check("R8 relatch rxne", r & 32'h4, 32'h4);
      for (int k = 0; k < 8; k++) begin
         hread(3'd1, r); check("R8 drain", r, {16'd0, 8'(8'h60 + k), 8'd0});
      end
      hread(3'd1, r); check("R8 collided byte gone", r, 32'h0);

      finish_run();
   end
endmodule